// File: doc/BRIEF.md
# Boot Region Lock and Identification Decoder

This block watches the write strobes on a flash device's command bus and recognises three keyed command sequences. One moves the device into an identification mode and another moves it back out. In identification mode, reads at a handful of low and high addresses are replaced with fixed code bytes and with the lock state of two boot regions. The third sequence is longer. It latches a permanent programming lock on either the lowest or the highest 16 KB region of the address space.

The program controller shares the same strobe bus. It uses two outputs from this block. The first is a per-address inhibit that is raised whenever the presented address falls in a locked region. The second is a chip-erase disable that is raised whenever either region is locked. A change of mode only takes effect after a settling pause of a parameterised length. Bus writes that arrive during that pause are ignored. The lock flags are never touched by reset. They are set only by the lock sequence or by a dedicated test-load port.

Top module: `boot_lock_id`

## Requirements
- R1: After the writes 0xAA to command address 0x5555, 0x55 to 0x2AAA and 0x90 to 0x5555 (command addresses compare on the low 15 address bits), identification mode becomes active exactly PAUSE_CYCLES clock edges after the edge that takes the third write, and not earlier.
- R2: The same two leading writes followed by 0xF0 to 0x5555 return the block to normal reads PAUSE_CYCLES edges after the edge that takes the third write.
- R3: In identification mode, a read with every address bit above bit 0 clear returns 0x1F when bit 0 is 0 and 0xC4 when bit 0 is 1.
- R4: In identification mode, a read of address 0x00002 returns 0xFE when the lower region is unlocked and 0xFF when it is locked. A read of the address with all bits set except that the low nibble is 0x2 reports the upper region in the same way.
- R5: The six writes AA/5555, 55/2AAA, 80/5555, AA/5555, 55/2AAA, 40/5555 arm the lock. A seventh write then sets a lock: 0x00 to full address 0 locks the lower region, and 0xFF to the all-ones address locks the upper region. Each region's lock is set independently of the other.
- R6: prog_inhibit is high exactly when bus_addr lies in a locked region. The lower region is the set of addresses with bits ADDR_W-1..REGION_W all zero. The upper region is the set with those bits all one.
- R7: chip_erase_dis is high when either lock flag is set and low when neither is set.
- R8: A write that does not match the next expected step returns the decoder to idle. It changes neither the mode nor the lock flags, and writes that follow are decoded from the first step.
- R9: Reset clears identification mode and the decoder but leaves both lock flags unchanged.
- R10: Writes that arrive while a mode-change pause is running are ignored.
- R11: While lock_load is high, both lock flags take the value of lock_load_val (bit 0 for the lower region, bit 1 for the upper). This can clear a lock, and it takes precedence over reset and over the lock sequence.
- R12: Outside identification mode, and in identification mode at any address not named in R3 or R4, rd_data equals mem_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle write strobe on the command bus |
| bus_addr | input | ADDR_W | Byte address of the current read or write |
| wr_data | input | 8 | Write data byte |
| mem_rdata | input | 8 | Data read from the array at bus_addr |
| rd_data | output | 8 | Read data after the identification override |
| prog_inhibit | output | 1 | bus_addr lies in a locked boot region |
| chip_erase_dis | output | 1 | At least one boot region is locked |
| lock_load | input | 1 | Test load enable for the lock flags |
| lock_load_val | input | 2 | Lock flag values applied by lock_load |

## Verification
The bench builds the block with ADDR_W = 19 and REGION_W = 14, so both region boundaries and the high status location 0x7FFF2 can be reached directly. PAUSE_CYCLES is 10 rather than the millisecond-scale default. That makes the exact cycle a mode change lands on observable. It also lets a complete three-write sequence be packed inside a single pause to show that those writes are dropped. Broken sequences are cut at a late step of the seven-write lock, and that lock is then completed, so that a missed restart would show up as an unwanted lock.

// File: rtl/boot_lock_id_pkg.sv
package boot_lock_id_pkg;

    localparam int CMD_W = 15;

    localparam logic [CMD_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [CMD_W-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [7:0] KEY_BYTE_A  = 8'hAA;
    localparam logic [7:0] KEY_BYTE_B  = 8'h55;
    localparam logic [7:0] OP_ID_ON    = 8'h90;
    localparam logic [7:0] OP_ID_OFF   = 8'hF0;
    localparam logic [7:0] OP_LOCK_PRE = 8'h80;
    localparam logic [7:0] OP_LOCK_ARM = 8'h40;
    localparam logic [7:0] LOCK_LO_BYTE = 8'h00;
    localparam logic [7:0] LOCK_HI_BYTE = 8'hFF;

    localparam logic [7:0] MAKER_CODE = 8'h1F;
    localparam logic [7:0] PART_CODE  = 8'hC4;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_LK1,
        SQ_LK2,
        SQ_LK3,
        SQ_ARMED
    } seq_state_t;

    typedef struct packed {
        logic id_on;
        logic id_off;
        logic set_lo;
        logic set_hi;
    } seq_cmd_t;

    function automatic logic [7:0] lock_status_byte(input logic locked);
        return {7'h7F, locked};
    endfunction

endpackage

// File: rtl/boot_seq_decoder.sv
module boot_seq_decoder
    import boot_lock_id_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output seq_cmd_t          cmd
);

    localparam logic [ADDR_W-1:0] ADDR_ZERO = '0;
    localparam logic [ADDR_W-1:0] ADDR_TOP  = '1;

    seq_state_t state_q, state_d;

    logic hit_a, hit_b;
    assign hit_a = (addr[CMD_W-1:0] == KEY_ADDR_A);
    assign hit_b = (addr[CMD_W-1:0] == KEY_ADDR_B);

    always_comb begin
        state_d = state_q;
        cmd     = '0;
        if (wr_ok) begin
            state_d = SQ_IDLE;
            unique case (state_q)
                SQ_IDLE: if (hit_a && data == KEY_BYTE_A) state_d = SQ_KEY1;
                SQ_KEY1: if (hit_b && data == KEY_BYTE_B) state_d = SQ_KEY2;
                SQ_KEY2: if (hit_a) begin
                    if (data == OP_ID_ON)    cmd.id_on  = 1'b1;
                    if (data == OP_ID_OFF)   cmd.id_off = 1'b1;
                    if (data == OP_LOCK_PRE) state_d    = SQ_LK1;
                end
                SQ_LK1:  if (hit_a && data == KEY_BYTE_A)  state_d = SQ_LK2;
                SQ_LK2:  if (hit_b && data == KEY_BYTE_B)  state_d = SQ_LK3;
                SQ_LK3:  if (hit_a && data == OP_LOCK_ARM) state_d = SQ_ARMED;
                SQ_ARMED: begin
                    cmd.set_lo = (addr == ADDR_ZERO) && (data == LOCK_LO_BYTE);
                    cmd.set_hi = (addr == ADDR_TOP)  && (data == LOCK_HI_BYTE);
                end
                default: state_d = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SQ_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/boot_mode_timer.sv
module boot_mode_timer #(
    parameter int PAUSE_CYCLES = 4_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic go_on,
    input  logic go_off,
    output logic id_mode,
    output logic busy
);

    localparam int CNT_W = $clog2(PAUSE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PAUSE_CYCLES);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             target_q;

    assign busy = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            target_q <= 1'b0;
            id_mode  <= 1'b0;
        end else if (go_on || go_off) begin
            cnt_q    <= LOAD_VAL;
            target_q <= go_on;
        end else if (busy) begin
            cnt_q <= cnt_q - ONE;
            if (cnt_q == ONE) id_mode <= target_q;
        end
    end

endmodule

// File: rtl/boot_lock_regs.sv
module boot_lock_regs #(
    parameter int ADDR_W   = 19,
    parameter int REGION_W = 14
) (
    input  logic              clk,
    input  logic              set_lo,
    input  logic              set_hi,
    input  logic              load,
    input  logic [1:0]        load_val,
    input  logic [ADDR_W-1:0] addr,
    output logic [1:0]        lock_q,
    output logic              inhibit
);

    localparam int TAG_W = ADDR_W - REGION_W;
    localparam logic [TAG_W-1:0] TAG_LO = '0;
    localparam logic [TAG_W-1:0] TAG_HI = '1;

    logic [TAG_W-1:0] tag;
    assign tag = addr[ADDR_W-1:REGION_W];

    always_ff @(posedge clk) begin
        if (load) begin
            lock_q <= load_val;
        end else begin
            if (set_lo) lock_q[0] <= 1'b1;
            if (set_hi) lock_q[1] <= 1'b1;
        end
    end

    assign inhibit = (lock_q[0] && tag == TAG_LO) || (lock_q[1] && tag == TAG_HI);

endmodule

// File: rtl/boot_lock_id.sv
module boot_lock_id
    import boot_lock_id_pkg::*;
#(
    parameter int ADDR_W       = 19,
    parameter int REGION_W     = 14,
    parameter int PAUSE_CYCLES = 4_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        rd_data,
    output logic              prog_inhibit,
    output logic              chip_erase_dis,
    input  logic              lock_load,
    input  logic [1:0]        lock_load_val
);

    localparam logic [ADDR_W-1:0] STAT_LO_ADDR = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] STAT_HI_ADDR = {{(ADDR_W-4){1'b1}}, 4'h2};

    seq_cmd_t   cmd;
    logic       id_mode;
    logic       busy;
    logic [1:0] lock_q;

    boot_seq_decoder #(.ADDR_W(ADDR_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .wr_ok (wr_stb && !busy),
        .addr  (bus_addr),
        .data  (wr_data),
        .cmd   (cmd)
    );

    boot_mode_timer #(.PAUSE_CYCLES(PAUSE_CYCLES)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .go_on   (cmd.id_on),
        .go_off  (cmd.id_off),
        .id_mode (id_mode),
        .busy    (busy)
    );

    boot_lock_regs #(.ADDR_W(ADDR_W), .REGION_W(REGION_W)) u_lock (
        .clk      (clk),
        .set_lo   (cmd.set_lo),
        .set_hi   (cmd.set_hi),
        .load     (lock_load),
        .load_val (lock_load_val),
        .addr     (bus_addr),
        .lock_q   (lock_q),
        .inhibit  (prog_inhibit)
    );

    assign chip_erase_dis = |lock_q;

    always_comb begin
        rd_data = mem_rdata;
        if (id_mode) begin
            if (bus_addr[ADDR_W-1:1] == '0)
                rd_data = bus_addr[0] ? PART_CODE : MAKER_CODE;
            else if (bus_addr == STAT_LO_ADDR)
                rd_data = lock_status_byte(lock_q[0]);
            else if (bus_addr == STAT_HI_ADDR)
                rd_data = lock_status_byte(lock_q[1]);
        end
    end

endmodule

// File: rtl/boot_lock_id_chk.sv
module boot_lock_id_chk (
    input logic       clk,
    input logic       rst,
    input logic       id_mode,
    input logic       busy,
    input logic [1:0] lock_q,
    input logic       lock_load,
    input logic       prog_inhibit,
    input logic       chip_erase_dis
);

    // R1
    mode_rise_after_pause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(id_mode) |-> $past(busy));

    // R2
    mode_fall_after_pause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(id_mode) |-> $past(busy));

    // R11
    lock_lo_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_q[0]) |-> $past(lock_load));

    // R11
    lock_hi_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_q[1]) |-> $past(lock_load));

    // R10
    pause_freezes_locks_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !lock_load) |=> $stable(lock_q));

    // R6
    no_lock_no_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_q == 2'b00) |-> !prog_inhibit);

    // R7
    erase_follows_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_q == 2'b00) |-> !chip_erase_dis);

    // R9
    reset_clears_mode_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !id_mode);

endmodule

bind boot_lock_id boot_lock_id_chk u_chk (.*);

// File: tb/sim_boot_lock_id.sv
module sim_boot_lock_id;

    localparam int AW = 19;
    localparam int P  = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    mem_rdata = '0;
    logic [7:0]    rd_data;
    logic          prog_inhibit;
    logic          chip_erase_dis;
    logic          lock_load = 1'b1;
    logic [1:0]    lock_load_val = 2'b00;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    boot_lock_id #(.ADDR_W(AW), .REGION_W(14), .PAUSE_CYCLES(P)) u0 (.*);

    typedef struct packed {
        logic [AW-1:0] a;
        logic [7:0]    m;
        logic [7:0]    e;
    } vec_t;

    // identification reads with both regions unlocked (R3, R4, R12)
    localparam vec_t VECS [6] = '{
        '{a: 19'h00000, m: 8'h11, e: 8'h1F},
        '{a: 19'h00001, m: 8'h22, e: 8'hC4},
        '{a: 19'h00002, m: 8'h33, e: 8'hFE},
        '{a: 19'h7FFF2, m: 8'h44, e: 8'hFE},
        '{a: 19'h00003, m: 8'h5A, e: 8'h5A},
        '{a: 19'h40001, m: 8'hA5, e: 8'hA5}
    };

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1; bus_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] m, output logic [7:0] r);
        bus_addr = a; mem_rdata = m;
        #0.5;
        r = rd_data;
    endtask

    task automatic seq_id(input logic [7:0] op);
        wr(19'h05555, 8'hAA);
        wr(19'h02AAA, 8'h55);
        wr(19'h05555, op);
    endtask

    task automatic seq_lock(input logic [AW-1:0] a, input logic [7:0] d);
        wr(19'h05555, 8'hAA);
        wr(19'h02AAA, 8'h55);
        wr(19'h05555, 8'h80);
        wr(19'h05555, 8'hAA);
        wr(19'h02AAA, 8'h55);
        wr(19'h05555, 8'h40);
        wr(a, d);
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        summary();
    end

    initial begin
        logic [7:0] r;
        wait_cyc(3);
        lock_load = 1'b0;
        rst = 1'b0;
        wait_cyc(1);

        // reset state
        rd(19'h00000, 8'h3C, r);
        chk("R12 reset passthrough", r, 8'h3C);
        chk("R7 reset erase", chip_erase_dis, 0);
        bus_addr = 19'h00100; #0.5;
        chk("R6 reset inhibit", prog_inhibit, 0);

        // R1 entry timing
        seq_id(8'h90);
        wait_cyc(P - 1);
        rd(19'h00000, 8'h3C, r);
        chk("R1 not before pause", r, 8'h3C);
        wait_cyc(1);
        rd(19'h00000, 8'h3C, r);
        chk("R1 active after pause", r, 8'h1F);

        foreach (VECS[i]) begin
            rd(VECS[i].a, VECS[i].m, r);
            chk("R3 R4 R12 id table", r, VECS[i].e);
        end

        // R2 exit timing
        seq_id(8'hF0);
        wait_cyc(P - 1);
        rd(19'h00001, 8'h77, r);
        chk("R2 still id before pause", r, 8'hC4);
        wait_cyc(1);
        rd(19'h00001, 8'h77, r);
        chk("R2 normal after pause", r, 8'h77);

        // R5 lock lower region
        seq_lock(19'h00000, 8'h00);
        wait_cyc(1);
        bus_addr = 19'h03FFF; #0.5;
        chk("R5 R6 lower locked", prog_inhibit, 1);
        bus_addr = 19'h04000; #0.5;
        chk("R6 just above lower", prog_inhibit, 0);
        bus_addr = 19'h7FFFF; #0.5;
        chk("R5 upper independent", prog_inhibit, 0);
        chk("R7 erase disabled", chip_erase_dis, 1);

        // R8 broken lock sequence: a wrong fifth write ends it
        wr(19'h05555, 8'hAA);
        wr(19'h02AAA, 8'h55);
        wr(19'h05555, 8'h80);
        wr(19'h05555, 8'hAA);
        wr(19'h02AAA, 8'h12);
        wr(19'h05555, 8'h40);
        wr(19'h7FFFF, 8'hFF);
        wait_cyc(1);
        bus_addr = 19'h7FFFF; #0.5;
        chk("R8 broken lock no effect", prog_inhibit, 0);
        // R8 broken entry sequence
        wr(19'h05555, 8'hAA);
        wr(19'h02AAB, 8'h55);
        wr(19'h05555, 8'h90);
        wait_cyc(P + 2);
        rd(19'h00000, 8'h66, r);
        chk("R8 broken entry no mode", r, 8'h66);

        // R5 lock upper region
        seq_lock(19'h7FFFF, 8'hFF);
        wait_cyc(1);
        bus_addr = 19'h7C000; #0.5;
        chk("R5 R6 upper locked", prog_inhibit, 1);
        bus_addr = 19'h7BFFF; #0.5;
        chk("R6 just below upper", prog_inhibit, 0);
        bus_addr = 19'h00000; #0.5;
        chk("R5 lower still locked", prog_inhibit, 1);

        // R4 status with both locked
        seq_id(8'h90);
        wait_cyc(P + 1);
        rd(19'h00002, 8'h00, r);
        chk("R4 lower status locked", r, 8'hFF);
        rd(19'h7FFF2, 8'h00, r);
        chk("R4 upper status locked", r, 8'hFF);

        // R10 writes during pause dropped
        seq_id(8'hF0);
        seq_id(8'h90);
        wait_cyc(P + 4);
        rd(19'h00000, 8'h99, r);
        chk("R10 pause writes ignored", r, 8'h99);

        // R9 reset leaves locks
        seq_id(8'h90);
        wait_cyc(P + 1);
        rd(19'h00000, 8'h99, r);
        chk("R9 in id before reset", r, 8'h1F);
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        wait_cyc(1);
        rd(19'h00000, 8'h99, r);
        chk("R9 reset leaves id", r, 8'h99);
        chk("R9 locks kept", prog_inhibit, 1);
        chk("R9 erase still disabled", chip_erase_dis, 1);

        // R11 test load clears
        lock_load = 1'b1; lock_load_val = 2'b10;
        wait_cyc(1);
        lock_load = 1'b0;
        bus_addr = 19'h00000; #0.5;
        chk("R11 lower cleared", prog_inhibit, 0);
        bus_addr = 19'h7FFFF; #0.5;
        chk("R11 upper loaded", prog_inhibit, 1);
        lock_load = 1'b1; lock_load_val = 2'b00;
        wait_cyc(1);
        lock_load = 1'b0;
        #0.5;
        chk("R7 erase re-enabled", chip_erase_dis, 0);

        summary();
    end

endmodule